// File: doc/BRIEF.md
# Link Error Counter with Threshold Event

This block counts error indications from one serial link and raises a sticky event once the count climbs above a programmed limit. A link controller places three copies side by side. One counts 8b/10b decode errors, one counts CRC errors, and one counts handshake errors, which are received R_ERR primitives. Each copy is set up by a parameter that selects its own bit in the interrupt status register.

Each copy holds a 16-bit count and a 16-bit limit, and both read back as one 32-bit word: the limit sits in bits [31:16] and the count in bits [15:0]. A write to that word loads a new limit and zeroes the count. A limit of zero turns the event off. Once the event is set it stays set until software takes one of two paths. The first is any write to the counter word. The second is a write of one to this copy's bit, or to its alias 16 positions higher, in the status register.

Top module: `link_err_cnt`

## Requirements
- R1: After reset the read word is 0x0000_0000 and `thr_event` is 0.
- R2: An `err_pulse` high at a clock edge, with no register write at that edge, raises the count in `reg_rdata[15:0]` by one after that edge.
- R3: The count saturates at 0xFFFF: further error pulses leave it at 0xFFFF.
- R4: A `reg_wr` loads the limit from `reg_wdata[31:16]` into `reg_rdata[31:16]` and sets the count to zero. `reg_wdata[15:0]` has no effect.
- R5: With a non-zero limit, `thr_event` rises at the edge after the one where the count becomes greater than the limit. A count equal to the limit does not set it.
- R6: With a limit of zero, `thr_event` stays 0 for any count.
- R7: Once set, `thr_event` stays 1 until a clear path is used.
- R8: A `reg_wr` with any data clears `thr_event` at that edge.
- R9: A `stat_clr_wr` clears `thr_event` when `stat_clr_data[STAT_BIT]` or `stat_clr_data[STAT_BIT+16]` is 1. The other bits of `stat_clr_data` have no effect.
- R10: A clear wins over a set at the same edge. If the count is still above a non-zero limit, `thr_event` sets again at the following edge.
- R11: When `err_pulse` and `reg_wr` arrive at the same edge, the write wins and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse | input | 1 | One error occurrence per cycle high |
| reg_wr | input | 1 | Write strobe for the counter word |
| reg_wdata | input | 32 | Write data: limit in [31:16] |
| reg_rdata | output | 32 | Read data: {limit, count} |
| stat_clr_wr | input | 1 | Write strobe for the status clear register |
| stat_clr_data | input | 32 | Status clear data, write one to clear |
| thr_event | output | 1 | Sticky limit-exceeded event |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a clear (a counter write or a status clear) and the event setting because the count is above the limit. The second pair is a counter write and an error pulse. Directed steps hold the count above the limit while a status clear is issued. They expect the event low right after the clear and high again one edge later. They also drive a write and a pulse together and expect a zero count. The random phase then mixes pulses, writes and clears at chosen rates, so that both kinds of overlap occur many times, and every edge is judged against a bench model.

// File: rtl/link_err_cnt.sv
module link_err_cnt #(
  parameter int CNT_W    = 16,
  parameter int STAT_BIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_pulse,
  input  logic               reg_wr,
  input  logic [2*CNT_W-1:0] reg_wdata,
  output logic [2*CNT_W-1:0] reg_rdata,
  input  logic               stat_clr_wr,
  input  logic [31:0]        stat_clr_data,
  output logic               thr_event
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, thr;
  logic clr_hit, over;

  assign clr_hit   = reg_wr | (stat_clr_wr & (stat_clr_data[STAT_BIT] | stat_clr_data[STAT_BIT+16]));
  assign over      = (thr != '0) && (cnt > thr);
  assign reg_rdata = {thr, cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      thr <= '0;
    end else if (reg_wr) begin
      cnt <= '0;
      thr <= reg_wdata[2*CNT_W-1:CNT_W];
    end else if (err_pulse && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thr_event <= 1'b0;
    else if (clr_hit) thr_event <= 1'b0;
    else if (over)    thr_event <= 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !reg_wr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !reg_wr) |=> cnt == CNT_MAX); // R3
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (cnt == '0 && !thr_event)); // R8
  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> !thr_event); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_event && !clr_hit) |=> thr_event); // R7
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_wr && (stat_clr_data[STAT_BIT] || stat_clr_data[STAT_BIT+16])) |=> !thr_event); // R9
endmodule

// File: tb/link_err_cnt_bench.sv
module link_err_cnt_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic err_pulse = 1'b0, reg_wr = 1'b0, stat_clr_wr = 1'b0;
  logic [31:0] reg_wdata = '0, stat_clr_data = '0, reg_rdata;
  logic thr_event;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cnt = '0, m_thr = '0;
  logic m_ev = 1'b0;

  always #5 clk = ~clk;

  link_err_cnt #(.CNT_W(16), .STAT_BIT(8)) u_link_err_cnt (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_clr_wr(stat_clr_wr),
    .stat_clr_data(stat_clr_data), .thr_event(thr_event));

  function automatic logic [15:0] exp_cnt(logic [15:0] c, logic e, logic w);
    if (w) return 16'h0;
    if (e && c != 16'hFFFF) return c + 16'h1;
    return c;
  endfunction

  function automatic logic exp_ev(logic ev, logic [15:0] c, logic [15:0] t,
                                  logic w, logic cw, logic [31:0] cd);
    if (w || (cw && (cd[8] || cd[24]))) return 1'b0;
    return ev || (t != 0 && c > t);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic e, logic w, logic [31:0] wd,
                      logic cw, logic [31:0] cd);
    logic nev;
    err_pulse = e; reg_wr = w; reg_wdata = wd; stat_clr_wr = cw; stat_clr_data = cd;
    @(posedge clk);
    nev = exp_ev(m_ev, m_cnt, m_thr, w, cw, cd);
    m_cnt = exp_cnt(m_cnt, e, w);
    if (w) m_thr = wd[31:16];
    m_ev = nev;
    @(negedge clk);
    check({tag, " word"}, reg_rdata, {m_thr, m_cnt});
    check({tag, " event"}, {31'h0, thr_event}, {31'h0, m_ev});
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    check("R1 reset word", reg_rdata, 32'h0);
    check("R1 reset event", {31'h0, thr_event}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R4 load limit", 0, 1, 32'h0003_ABCD, 0, 0);
    check("R4 low data ignored", reg_rdata, 32'h0003_0000);
    for (int i = 0; i < 3; i++) step("R2 count", 1, 0, 0, 0, 0);
    idle("R5 equal no event");
    check("R5 equal", {31'h0, thr_event}, 32'h0);
    step("R5 exceed", 1, 0, 0, 0, 0);
    idle("R5 rise");
    check("R5 raised", {31'h0, thr_event}, 32'h1);
    for (int i = 0; i < 4; i++) idle("R7 sticky");
    step("R9 other bit", 0, 0, 0, 1, 32'hFEFF_FEFF);
    check("R9 other bits keep", {31'h0, thr_event}, 32'h1);
    step("R10 clear vs set", 0, 0, 0, 1, 32'h0100_0000);
    check("R10 cleared", {31'h0, thr_event}, 32'h0);
    idle("R10 reset again");
    check("R10 re-set", {31'h0, thr_event}, 32'h1);
    step("R9 low bit clear", 0, 0, 0, 1, 32'h0000_0100);
    step("R8 write clears", 0, 1, 32'h0003_0000, 0, 0);
    check("R8 cleared", {31'h0, thr_event}, 32'h0);
    for (int i = 0; i < 3; i++) step("R2 recount", 1, 0, 0, 0, 0);
    step("R11 write with pulse", 1, 1, 32'h0000_FFFF, 0, 0);
    check("R11 zero count", reg_rdata, 32'h0);
    for (int i = 0; i < 8; i++) step("R6 zero limit", 1, 0, 0, 0, 0);
    check("R6 no event", {31'h0, thr_event}, 32'h0);

    step("R3 prep", 0, 1, 32'hFFFF_0000, 0, 0);
    for (int i = 0; i < 65540; i++) begin
      err_pulse = 1'b1; reg_wr = 1'b0; stat_clr_wr = 1'b0;
      @(posedge clk);
      m_cnt = exp_cnt(m_cnt, 1'b1, 1'b0);
      @(negedge clk);
    end
    check("R3 saturate", reg_rdata, 32'hFFFF_FFFF);
    step("R3 hold", 1, 0, 0, 0, 0);
    check("R6 limit max no event", {31'h0, thr_event}, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic e, w, cw;
      logic [31:0] wd, cd;
      e  = ($urandom % 4) != 0;
      w  = ($urandom % 40) == 0;
      cw = ($urandom % 15) == 0;
      wd = {16'($urandom % 12), 16'($urandom)};
      cd = $urandom;
      step("R2 R5 R10 random", e, w, wd, cw, cd);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule